// File: doc/BRIEF.md
# Inter-Stage Extrinsic Precision Rescaler

A pipelined iterative decoder passes extrinsic values from one half-iteration stage to the next. The words keep the same width at every stage, but their meaning changes. As decoding goes on, the extrinsic values grow. At a few chosen stages the number of fractional bits is therefore cut by one, which gives the same word a wider range. This block sits on that path. It takes an extrinsic word written in the format of the previous stage and rewrites it in the format of the stage it is entering.

The stages where precision is reduced are set at build time by a gain profile of three stage indices. An index listed twice removes two fractional bits at that stage. The channel log-likelihood ratio keeps one fixed format for the whole decode. The block also brings the extrinsic value and the channel value to a common precision, the smaller of the two. It does this by arithmetic right shifts with round-half-up and a saturating clamp. The stage that follows then works at that common precision.

Each accepted sample gives a registered result one cycle later, with a valid flag and the common precision in use.

Top module: `ext_rescaler`

## Requirements
- R1: While reset is held and directly after it, `outValid` is 0 and every data output and `outFrac` is 0.
- R2: `outValid` is 1 exactly in the cycle after a cycle with `inValid` = 1, and 0 otherwise (one cycle of latency).
- R3: The precision of stage s is p(s) = INIT_FRAC minus the number of profile entries (GAIN0, GAIN1, GAIN2) that are less than or equal to s. `outFrac` reports the common precision min(p(s), LLR_FRAC) as a signed two's complement number.
- R4: `outExt` is `inExt` read at precision p(s-1), which is INIT_FRAC minus the entries strictly below s, and rewritten at p(s). The conversion adds half of the dropped LSB weight and then shifts right arithmetically, so the result is floor(x·2^(p(s)−p(s−1)) + 0.5).
- R5: At a stage whose index is not in the profile, `outExt` equals `inExt` unchanged.
- R6: A stage index that appears twice in the profile lowers the precision by two bits at that stage. The extrinsic word is then shifted right by 2 with rounding.
- R7: `outAlignExt` and `outAlignLlr` are the extrinsic value (read at p(s-1)) and the channel value (read at LLR_FRAC, whatever the stage), both rounded to the common precision of R3. Only the operand with the higher precision is shifted.
- R8: Rounding of extreme codes does not wrap: with 5-bit words and a 1-bit shift, +15 becomes +8 and −16 becomes −8. Any result beyond the word range would saturate to the most positive or most negative code.
- R9: When `inValid` is 0, all data outputs and `outFrac` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample present |
| inStage | input | STAGE_W | Index of the stage the sample is entering |
| inExt | input | DATA_W | Extrinsic value, two's complement, format of the previous stage |
| inLlr | input | DATA_W | Channel LLR, two's complement, LLR_FRAC fractional bits |
| outValid | output | 1 | Registered result present |
| outExt | output | DATA_W | Extrinsic value in the format of stage `inStage` |
| outAlignExt | output | DATA_W | Extrinsic value at the common precision |
| outAlignLlr | output | DATA_W | Channel LLR at the common precision |
| outFrac | output | FRAC_W | Common precision, signed |

## Verification
Stages 0 to 13 are swept under the profile 11-3-7. At each stage the inputs include odd and even codes, values whose dropped bit is exactly one half, and the two extreme codes. This separates correct round-half-up from truncation, from round-to-nearest-even and from wrong shift counts. It also shows whether the stage comparison uses "less than or equal" rather than "less than". Results are compared against a real-valued model. A second instance with a repeated profile entry confirms the two-bit drop. Idle cycles with changing inputs confirm that the outputs hold and that the valid flag has exactly one cycle of latency.

// File: rtl/ext_rescaler_pkg.sv
package ext_rescaler_pkg;
  localparam int SHIFT_W = 4;
  localparam int FRAC_W  = 4;

  typedef struct packed {
    logic                     load;
    logic [SHIFT_W-1:0]       extShift;
    logic [SHIFT_W-1:0]       extAlignShift;
    logic [SHIFT_W-1:0]       llrAlignShift;
    logic signed [FRAC_W-1:0] frac;
  } rescaleStrobe_t;
endpackage

// File: rtl/ext_round_lane.sv
module ext_round_lane #(
  parameter int W    = 5,
  parameter int SH_W = 4
) (
  input  logic signed [W-1:0] x,
  input  logic [SH_W-1:0]     k,
  output logic signed [W-1:0] y
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = XW'((1 <<< (W - 1)) - 1);
  localparam logic signed [XW-1:0] MINV = -MAXV - XW'(1);

  logic signed [XW-1:0] wide, half, sum, shifted;

  always_comb begin
    wide    = XW'(x);
    half    = (k == '0) ? '0 : (XW'(1) <<< (k - 1'b1));
    sum     = wide + half;
    shifted = sum >>> k;
    if (shifted > MAXV)      y = MAXV[W-1:0];
    else if (shifted < MINV) y = MINV[W-1:0];
    else                     y = shifted[W-1:0];
  end
endmodule

// File: rtl/ext_rescaler_ctrl.sv
module ext_rescaler_ctrl
  import ext_rescaler_pkg::*;
#(
  parameter int DATA_W    = 5,
  parameter int STAGE_W   = 5,
  parameter int INIT_FRAC = 2,
  parameter int LLR_FRAC  = 2,
  parameter int GAIN0     = 11,
  parameter int GAIN1     = 3,
  parameter int GAIN2     = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [STAGE_W-1:0] inStage,
  output rescaleStrobe_t     strobe
);
  localparam int NUM_GAIN = 3;
  localparam int PROFILE [NUM_GAIN] = '{GAIN0, GAIN1, GAIN2};

  function automatic int capShift(int v);
    if (v < 0)      return 0;
    if (v > DATA_W) return DATA_W;
    return v;
  endfunction

  int cntLe, cntLt, pOut, pIn, pCommon;

  always_comb begin
    cntLe = 0;
    cntLt = 0;
    for (int i = 0; i < NUM_GAIN; i++) begin
      if (PROFILE[i] <= int'(inStage)) cntLe = cntLe + 1;
      if (PROFILE[i] <  int'(inStage)) cntLt = cntLt + 1;
    end
    pOut    = INIT_FRAC - cntLe;
    pIn     = INIT_FRAC - cntLt;
    pCommon = (pOut < LLR_FRAC) ? pOut : LLR_FRAC;
  end

  always_comb begin
    strobe.load          = inValid;
    strobe.extShift      = SHIFT_W'(capShift(pIn - pOut));
    strobe.extAlignShift = SHIFT_W'(capShift(pIn - pCommon));
    strobe.llrAlignShift = SHIFT_W'(capShift(LLR_FRAC - pCommon));
    strobe.frac          = FRAC_W'(pCommon);
  end

  AST_FRAC_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (int'(strobe.frac) <= LLR_FRAC)); // R3
  AST_ALIGN_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (strobe.extAlignShift >= strobe.extShift)); // R7
  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> ((strobe.extAlignShift == strobe.extShift) || (strobe.llrAlignShift == '0))); // R7
endmodule

// File: rtl/ext_rescaler_dp.sv
module ext_rescaler_dp
  import ext_rescaler_pkg::*;
#(
  parameter int DATA_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rescaleStrobe_t           strobe,
  input  logic signed [DATA_W-1:0] inExt,
  input  logic signed [DATA_W-1:0] inLlr,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outExt,
  output logic signed [DATA_W-1:0] outAlignExt,
  output logic signed [DATA_W-1:0] outAlignLlr,
  output logic signed [FRAC_W-1:0] outFrac
);
  localparam int NUM_LANE = 3;

  logic signed [DATA_W-1:0] laneIn  [NUM_LANE];
  logic [SHIFT_W-1:0]       laneK   [NUM_LANE];
  logic signed [DATA_W-1:0] laneOut [NUM_LANE];

  always_comb begin
    laneIn[0] = inExt;  laneK[0] = strobe.extShift;
    laneIn[1] = inExt;  laneK[1] = strobe.extAlignShift;
    laneIn[2] = inLlr;  laneK[2] = strobe.llrAlignShift;
  end

  for (genvar g = 0; g < NUM_LANE; g++) begin : gLane
    ext_round_lane #(.W(DATA_W), .SH_W(SHIFT_W)) uLane (
      .x(laneIn[g]),
      .k(laneK[g]),
      .y(laneOut[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outExt      <= '0;
      outAlignExt <= '0;
      outAlignLlr <= '0;
      outFrac     <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        outExt      <= laneOut[0];
        outAlignExt <= laneOut[1];
        outAlignLlr <= laneOut[2];
        outFrac     <= strobe.frac;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(outExt) && $stable(outAlignLlr) && $stable(outFrac))); // R9
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> ((outExt == '0) || (outExt[DATA_W-1] == $past(inExt[DATA_W-1])))); // R8
  AST_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && inExt >= 0) |=> (outExt <= $past(inExt))); // R4
endmodule

// File: rtl/ext_rescaler.sv
module ext_rescaler
  import ext_rescaler_pkg::*;
#(
  parameter int DATA_W    = 5,
  parameter int STAGE_W   = 5,
  parameter int INIT_FRAC = 2,
  parameter int LLR_FRAC  = 2,
  parameter int GAIN0     = 11,
  parameter int GAIN1     = 3,
  parameter int GAIN2     = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [STAGE_W-1:0]       inStage,
  input  logic signed [DATA_W-1:0] inExt,
  input  logic signed [DATA_W-1:0] inLlr,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outExt,
  output logic signed [DATA_W-1:0] outAlignExt,
  output logic signed [DATA_W-1:0] outAlignLlr,
  output logic signed [FRAC_W-1:0] outFrac
);
  rescaleStrobe_t strobe;

  ext_rescaler_ctrl #(
    .DATA_W(DATA_W), .STAGE_W(STAGE_W), .INIT_FRAC(INIT_FRAC),
    .LLR_FRAC(LLR_FRAC), .GAIN0(GAIN0), .GAIN1(GAIN1), .GAIN2(GAIN2)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStage(inStage), .strobe(strobe)
  );

  ext_rescaler_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inExt(inExt), .inLlr(inLlr),
    .outValid(outValid), .outExt(outExt), .outAlignExt(outAlignExt),
    .outAlignLlr(outAlignLlr), .outFrac(outFrac)
  );
endmodule

// File: tb/ext_rescaler_test.sv
module ext_rescaler_test;
  localparam int DW = 5;
  localparam int P0 = 2;
  localparam int PL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [4:0] inStage = '0;
  logic signed [DW-1:0] inExt = '0;
  logic signed [DW-1:0] inLlr = '0;
  logic outValid, outValid2;
  logic signed [DW-1:0] outExt, outAlignExt, outAlignLlr;
  logic signed [DW-1:0] outExt2, outAlignExt2, outAlignLlr2;
  logic signed [3:0] outFrac, outFrac2;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ext_rescaler uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStage(inStage),
    .inExt(inExt), .inLlr(inLlr), .outValid(outValid), .outExt(outExt),
    .outAlignExt(outAlignExt), .outAlignLlr(outAlignLlr), .outFrac(outFrac)
  );

  ext_rescaler #(.GAIN0(5), .GAIN1(5), .GAIN2(30)) uut2 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStage(inStage),
    .inExt(inExt), .inLlr(inLlr), .outValid(outValid2), .outExt(outExt2),
    .outAlignExt(outAlignExt2), .outAlignLlr(outAlignLlr2), .outFrac(outFrac2)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int precAt(int s, int g0, int g1, int g2, bit inclusive);
    int c = 0;
    if (inclusive) c = int'(g0 <= s) + int'(g1 <= s) + int'(g2 <= s);
    else           c = int'(g0 < s) + int'(g1 < s) + int'(g2 < s);
    return P0 - c;
  endfunction

  function automatic int model(int x, int pFrom, int pTo);
    real v;
    int r;
    v = $itor(x) * (2.0 ** (pTo - pFrom)) + 0.5;
    r = int'($floor(v));
    if (r > 15) r = 15;
    if (r < -16) r = -16;
    return r;
  endfunction

  // present one sample at a negedge, check the registered result one cycle later
  task automatic applyMain(input int s, input int x, input int l);
    int pin, pout, pc;
    @(negedge clk);
    inValid = 1'b1; inStage = 5'(s); inExt = DW'(x); inLlr = DW'(l);
    @(negedge clk);
    pin = precAt(s, 11, 3, 7, 1'b0);
    pout = precAt(s, 11, 3, 7, 1'b1);
    pc = (pout < PL) ? pout : PL;
    check($sformatf("R2 valid stage %0d", s), int'(outValid), 1);
    check($sformatf("R4/R5 ext stage %0d x %0d", s, x), int'(outExt), model(x, pin, pout));
    check($sformatf("R7 alignExt stage %0d x %0d", s, x), int'(outAlignExt), model(x, pin, pc));
    check($sformatf("R7 alignLlr stage %0d l %0d", s, l), int'(outAlignLlr), model(l, PL, pc));
    check($sformatf("R3 frac stage %0d", s), int'(outFrac), pc);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 valid in reset", int'(outValid), 0);
    check("R1 ext in reset", int'(outExt), 0);
    check("R1 llr in reset", int'(outAlignLlr), 0);
    check("R1 frac in reset", int'(outFrac), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(outValid), 0);
    check("R1 alignExt after reset", int'(outAlignExt), 0);
  endtask

  task automatic testSweep();
    int vals [8] = '{-16, -5, -1, 0, 1, 3, 6, 15};
    for (int s = 0; s < 14; s++)
      for (int i = 0; i < 8; i++)
        applyMain(s, vals[i], vals[7 - i]);
  endtask

  task automatic testUnchanged();
    // R5: stages 0,5,9,13 are not in the profile
    applyMain(5, -7, 4);
    check("R5 passthrough stage 5", int'(outExt), -7);
    applyMain(9, 13, -3);
    check("R5 passthrough stage 9", int'(outExt), 13);
  endtask

  task automatic testExtremes();
    applyMain(3, 15, 15);
    check("R8 max code stage 3", int'(outExt), 8);
    applyMain(3, -16, -16);
    check("R8 min code stage 3", int'(outExt), -8);
    check("R8 min llr stage 3", int'(outAlignLlr), -8);
    applyMain(11, 15, 15);
    check("R8 max code stage 11", int'(outExt), 8);
    check("R8 max llr stage 11 shift 3", int'(outAlignLlr), 2);
  endtask

  task automatic testHold();
    applyMain(7, 5, -9);
    for (int i = 0; i < 3; i++) begin
      inStage = 5'(i); inExt = DW'(-11 + i); inLlr = DW'(6 - i);
      @(negedge clk);
      check("R2 no valid when idle", int'(outValid), 0);
      check("R9 ext held", int'(outExt), 3);
      check("R9 alignLlr held", int'(outAlignLlr), -2);
      check("R9 frac held", int'(outFrac), 0);
    end
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    inValid = 1'b1; inStage = 5'd3; inExt = DW'(5); inLlr = DW'(3);
    @(negedge clk);
    check("R2 first of pair valid", int'(outValid), 1);
    check("R4 first of pair", int'(outExt), 3);
    inStage = 5'd4; inExt = DW'(-3); inLlr = DW'(-3);
    @(negedge clk);
    check("R2 second of pair valid", int'(outValid), 1);
    check("R4 second of pair", int'(outExt), -3);
    check("R7 second of pair llr", int'(outAlignLlr), -1);
    inValid = 1'b0;
    @(negedge clk);
    check("R2 valid drops", int'(outValid), 0);
  endtask

  task automatic testRepeated();
    int xs [4] = '{7, -6, 2, -16};
    int ex [4] = '{2, -1, 1, -4};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b1; inStage = 5'd5; inExt = DW'(xs[i]); inLlr = DW'(xs[i]);
      @(negedge clk);
      check($sformatf("R6 double drop x %0d", xs[i]), int'(outExt2), ex[i]);
      check($sformatf("R6 llr x %0d", xs[i]), int'(outAlignLlr2), ex[i]);
      check("R6 frac", int'(outFrac2), 0);
      inValid = 1'b0;
    end
    @(negedge clk);
    inValid = 1'b1; inStage = 5'd4; inExt = DW'(7); inLlr = DW'(1);
    @(negedge clk);
    check("R6 stage before repeat", int'(outExt2), 7);
    check("R6 frac before repeat", int'(outFrac2), 2);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testSweep();
    testUnchanged();
    testExtremes();
    testHold();
    testBackToBack();
    testRepeated();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule